// File: doc/BRIEF.md
# Logarithmic-Domain Arithmetic Unit

This unit computes on real numbers that are kept as a sign, a zero marker and a base-2 logarithm in two's-complement fixed point. Because every nonzero magnitude is stored as its logarithm, the multiplicative operations become cheap fixed-point work. Products and quotients are an add or a subtract of logarithms. Integer powers multiply the logarithm by a small integer, and integer roots divide it by one, the root using a short bit-serial divider. Addition and subtraction first pick the operand of larger magnitude and the logarithm difference. They then add a correction from a constant table indexed by that difference, quantized to quarter steps.

Each operand is a 64-bit word, but the unit sits on a 32-bit processor port. An operation is therefore loaded as four 32-bit input beats, and its result leaves as two 32-bit output beats, each side with its own valid/ready handshake. One operation is in flight at a time. Conversion between linear and logarithmic form happens elsewhere.

Top module: `lns_unit`

## Requirements
- R1: A word has the sign in bit 63, the zero marker in bit 62, and the logarithm as a LOG_W-bit two's-complement value with FRAC_W fractional bits in bits [LOG_W-1:0]. The bits between them are ignored on input and zero on output, and zero is 0x4000_0000_0000_0000. An operation is loaded as four beats: A low, A high, B low, B high. The operation code `inOp` is taken on the first beat. After reset `inReady` is high and `outValid` is low.
- R2: A result leaves as two beats, low word first, and `outErr` accompanies both. While `outValid` is high and `outReady` is low, `outValid` and `outData` hold still.
- R3: Multiply (code 0) returns the log sum with sign A xor B. It returns zero when either operand carries the zero marker.
- R4: Divide (code 1) returns log A minus log B with sign A xor B. A zero divisor sets `outErr` with the zero word. A zero dividend returns zero.
- R5: Power (code 2) takes n from B bits [7:0]. It returns log A times n, truncated to LOG_W bits, with sign A and n[0]. n = 0 returns +1.0 (sign 0, log 0). A zero base with n > 0 returns zero.
- R6: Root (code 3) takes n from B bits [7:0]. It returns log A divided by n, truncated toward zero, with the sign of A. n = 0, or a negative A with even n, sets `outErr` with the zero word. A zero A with n > 0 returns zero.
- R7: Add (code 4) and subtract (code 5) flip B's sign for subtract. The operand with the larger log (A on a tie) gives the result sign. Let d be the log difference and k = floor(4·d). When the effective signs match, the result log is the larger log plus log2(1 + 2^(-k/4)), within 3 LSB.
- R8: When the effective signs differ, the result log is the larger log plus log2(1 − 2^(-(k+1)/4)), within 3 LSB. Equal logs give the zero word.
- R9: When k is 64 or more (d ≥ 16.0), the larger operand is returned unchanged.
- R10: In add or subtract, an operand with the zero marker yields the other operand, B carrying its effective sign. Two zeros give zero.
- R11: Count the edge that accepts the fourth input beat as edge 0. The first output beat is presented after edge 1 for every code except root, and after edge LOG_W+2 for root.
- R12: Codes 6 and 7 set `outErr` with the zero word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input beat offered |
| inReady | output | 1 | Unit is collecting input beats |
| inData | input | 32 | Input beat |
| inOp | input | 3 | Operation code, taken on the first beat |
| outValid | output | 1 | Result beat offered |
| outReady | input | 1 | Consumer takes the result beat |
| outData | output | 32 | Result beat, low word first |
| outErr | output | 1 | Error flag of the current result |

## Verification
Every result except a root result is due one idle cycle after the fourth input beat is accepted. A root result is due LOG_W+2 edges after that beat, because the divider runs one step per cycle. The driver records the cycle in which it offers the accepted last beat. The monitor measures the gap to the first `outValid` and compares it with the latency queued with the expected word, so an early, late or missing result is reported even if its value is right. Table-based sums are compared within a small tolerance against values the bench computes in floating point. Every other result is compared bit for bit.

// File: rtl/lns_pkg.sv
package lns_pkg;

  typedef enum logic [2:0] {
    OP_MUL  = 3'd0,
    OP_DIV  = 3'd1,
    OP_POW  = 3'd2,
    OP_ROOT = 3'd3,
    OP_ADD  = 3'd4,
    OP_SUB  = 3'd5
  } lnsOp_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic       capture;  // input beat taken this cycle
    logic [1:0] beat;     // index of that beat
    logic       start;    // evaluate, or seed the root divider
    logic       divStep;  // one divider iteration
    logic       finish;   // write the root result
    logic       sendHi;   // present the upper result word
  } lnsStrobe_t;

  // Correction log2(1 +/- 2^(-k/4)) in fixed point with 'frac' fraction bits,
  // computed with integer arithmetic on 30-bit fractions.
  function automatic longint lnsCorr(input int k, input int frac, input bit isSub);
    longint c, y, z, e, r;
    case (k & 3)
      0:       c = longint'(1) <<< 30;
      1:       c = longint'(902905653);  // 2^-0.25
      2:       c = longint'(759250125);  // 2^-0.50
      default: c = longint'(638450709);  // 2^-0.75
    endcase
    y = c >>> (k >> 2);
    z = isSub ? (longint'(1) <<< 30) - y : (longint'(1) <<< 30) + y;
    e = 0;
    for (int i = 0; i < 40; i++) begin
      if (z >= (longint'(2) <<< 30)) begin
        z = z >>> 1;
        e = e + 1;
      end else if (z < (longint'(1) <<< 30) && z > 0) begin
        z = z <<< 1;
        e = e - 1;
      end
    end
    r = 0;
    for (int i = 0; i < frac; i++) begin
      z = (z * z) >>> 30;
      r = r <<< 1;
      if (z >= (longint'(2) <<< 30)) begin
        z = z >>> 1;
        r = r + 1;
      end
    end
    return (e <<< frac) + r;
  endfunction

endpackage

// File: rtl/lns_corr_rom.sv
module lns_corr_rom #(
  parameter int LOG_W  = 32,
  parameter int FRAC_W = 16,
  parameter int TAB_N  = 64
) (
  input  logic [$clog2(TAB_N)-1:0] idx,
  output logic signed [LOG_W-1:0]  addCorr,
  output logic signed [LOG_W-1:0]  subCorr
);

  logic signed [LOG_W-1:0] addTab [TAB_N];
  logic signed [LOG_W-1:0] subTab [TAB_N];

  // add entries sampled at the low edge of each step, subtract entries at the
  // high edge so that no entry sits on the singular point at zero distance
  for (genvar k = 0; k < TAB_N; k++) begin : g_entry
    localparam longint ADD_V = lns_pkg::lnsCorr(k, FRAC_W, 1'b0);
    localparam longint SUB_V = lns_pkg::lnsCorr(k + 1, FRAC_W, 1'b1);
    assign addTab[k] = LOG_W'(ADD_V);
    assign subTab[k] = LOG_W'(SUB_V);
  end

  assign addCorr = addTab[idx];
  assign subCorr = subTab[idx];

endmodule

// File: rtl/lns_ctrl.sv
module lns_ctrl
  import lns_pkg::*;
#(
  parameter int LOG_W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  input  logic       opIsRoot,
  output logic       inReady,
  output logic       outValid,
  output lnsStrobe_t ctl
);

  localparam int CNT_W = $clog2(LOG_W);

  typedef enum logic [2:0] {S_LOAD, S_EXEC, S_DIV, S_FIN, S_SEND} state_e;

  state_e           state;
  logic [1:0]       beatCnt;
  logic [CNT_W-1:0] divCnt;
  logic             sendHi;

  assign inReady  = (state == S_LOAD);
  assign outValid = (state == S_SEND);

  always_comb begin
    ctl         = '0;
    ctl.capture = inValid && inReady;
    ctl.beat    = beatCnt;
    ctl.start   = (state == S_EXEC);
    ctl.divStep = (state == S_DIV);
    ctl.finish  = (state == S_FIN);
    ctl.sendHi  = sendHi;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_LOAD;
      beatCnt <= '0;
      divCnt  <= '0;
      sendHi  <= 1'b0;
    end else begin
      case (state)
        S_LOAD: if (ctl.capture) begin
          beatCnt <= beatCnt + 2'd1;
          if (beatCnt == 2'd3) state <= S_EXEC;
        end
        S_EXEC: begin
          divCnt <= '0;
          sendHi <= 1'b0;
          state  <= opIsRoot ? S_DIV : S_SEND;
        end
        S_DIV: begin
          divCnt <= divCnt + 1'b1;
          if (divCnt == CNT_W'(LOG_W - 1)) state <= S_FIN;
        end
        S_FIN:  state <= S_SEND;
        S_SEND: if (outReady) begin
          if (sendHi) begin
            sendHi <= 1'b0;
            state  <= S_LOAD;
          end else begin
            sendHi <= 1'b1;
          end
        end
        default: state <= S_LOAD;
      endcase
    end
  end

  AST_DIV_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EXEC && opIsRoot) |=> (state == S_DIV && divCnt == '0)); // R11

  AST_LOAD_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && beatCnt == 2'd3) |=> (state == S_EXEC && !inReady)); // R1

endmodule

// File: rtl/lns_datapath.sv
module lns_datapath
  import lns_pkg::*;
#(
  parameter int LOG_W  = 32,
  parameter int FRAC_W = 16,
  parameter int TAB_N  = 64,
  parameter int N_W    = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  lnsStrobe_t  ctl,
  input  logic [31:0] inData,
  input  logic [2:0]  inOp,
  output logic        opIsRoot,
  output logic [31:0] outData,
  output logic        outErr
);

  localparam int          IDX_W      = $clog2(TAB_N);
  localparam int          STEP_SHIFT = FRAC_W - 2;
  localparam int          PAD_W      = 62 - LOG_W;
  localparam logic [63:0] ZERO_WORD  = {2'b01, 62'd0};

  logic [63:0] opA, opB;
  lnsOp_e      opCode;
  logic [63:0] resWord;
  logic        resErr;

  function automatic logic [63:0] packWord(input logic s, input logic [LOG_W-1:0] l);
    return {s, 1'b0, {PAD_W{1'b0}}, l};
  endfunction

  // operand fields
  logic                    aS, aZ, bS, bZ, bSeff;
  logic signed [LOG_W-1:0] aL, bL;
  logic [N_W-1:0]          nVal;
  logic [63:0]             unusedBits;

  assign aS         = opA[63];
  assign aZ         = opA[62];
  assign aL         = opA[LOG_W-1:0];
  assign bS         = opB[63];
  assign bZ         = opB[62];
  assign bL         = opB[LOG_W-1:0];
  assign nVal       = opB[N_W-1:0];
  assign bSeff      = bS ^ (opCode == OP_SUB);
  assign opIsRoot   = (opCode == OP_ROOT);
  assign unusedBits = {opA[61:LOG_W], opB[61:LOG_W], {(2 * LOG_W + 4){1'b0}}};

  // add/subtract: larger operand, distance, table correction
  logic                    aGe, bigS, sameSign, far;
  logic signed [LOG_W-1:0] bigL, smallL, sumL;
  logic [LOG_W:0]          diff, idxFull;
  logic signed [LOG_W-1:0] addCorr, subCorr;

  assign aGe      = (aL >= bL);
  assign bigL     = aGe ? aL : bL;
  assign smallL   = aGe ? bL : aL;
  assign bigS     = aGe ? aS : bSeff;
  assign sameSign = (aS == bSeff);
  assign diff     = {bigL[LOG_W-1], bigL} - {smallL[LOG_W-1], smallL};
  assign idxFull  = diff >> STEP_SHIFT;
  assign far      = (idxFull >= (LOG_W + 1)'(TAB_N));
  assign sumL     = far ? bigL : bigL + (sameSign ? addCorr : subCorr);

  lns_corr_rom #(.LOG_W(LOG_W), .FRAC_W(FRAC_W), .TAB_N(TAB_N)) i_rom (
    .idx     (idxFull[IDX_W-1:0]),
    .addCorr (addCorr),
    .subCorr (subCorr)
  );

  // power: log times n
  logic signed [LOG_W+N_W:0] powFull;
  assign powFull = $signed({{(N_W + 1){aL[LOG_W-1]}}, aL}) * $signed({{(LOG_W + 1){1'b0}}, nVal});

  // single-cycle result
  logic [63:0] nxtWord;
  logic        nxtErr;

  always_comb begin
    nxtWord = ZERO_WORD;
    nxtErr  = 1'b0;
    case (opCode)
      OP_MUL: if (!(aZ || bZ)) nxtWord = packWord(aS ^ bS, aL + bL);
      OP_DIV: begin
        if (bZ)       nxtErr  = 1'b1;
        else if (!aZ) nxtWord = packWord(aS ^ bS, aL - bL);
      end
      OP_POW: begin
        if (nVal == '0) nxtWord = packWord(1'b0, '0);
        else if (!aZ)   nxtWord = packWord(aS & nVal[0], powFull[LOG_W-1:0]);
      end
      OP_ADD, OP_SUB: begin
        if (aZ && bZ)                     nxtWord = ZERO_WORD;
        else if (aZ)                      nxtWord = packWord(bSeff, bL);
        else if (bZ)                      nxtWord = packWord(aS, aL);
        else if (!sameSign && diff == '0) nxtWord = ZERO_WORD;
        else                              nxtWord = packWord(bigS, sumL);
      end
      OP_ROOT: nxtErr = 1'b0;
      default: nxtErr = 1'b1;
    endcase
  end

  // bit-serial root divider: |log| / n
  logic [LOG_W-1:0] qReg, magA;
  logic [N_W-1:0]   rReg;
  logic [N_W:0]     trial;
  logic             trialFits;

  assign magA      = aL[LOG_W-1] ? LOG_W'(-aL) : LOG_W'(aL);
  assign trial     = {rReg, qReg[LOG_W-1]};
  assign trialFits = (trial >= {1'b0, nVal});

  logic signed [LOG_W-1:0] rootL;
  logic                    rootErr;
  logic [63:0]             rootWord;

  assign rootL    = aL[LOG_W-1] ? -$signed(qReg) : $signed(qReg);
  assign rootErr  = (nVal == '0) || (!aZ && aS && !nVal[0]);
  assign rootWord = (rootErr || aZ) ? ZERO_WORD : packWord(aS, rootL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opA     <= '0;
      opB     <= '0;
      opCode  <= OP_MUL;
      resWord <= '0;
      resErr  <= 1'b0;
      qReg    <= '0;
      rReg    <= '0;
    end else begin
      if (ctl.capture) begin
        case (ctl.beat)
          2'd0: begin
            opA[31:0] <= inData;
            opCode    <= lnsOp_e'(inOp);
          end
          2'd1:    opA[63:32] <= inData;
          2'd2:    opB[31:0]  <= inData;
          default: opB[63:32] <= inData;
        endcase
      end
      if (ctl.start) begin
        if (opCode == OP_ROOT) begin
          qReg <= magA;
          rReg <= '0;
        end else begin
          resWord <= nxtWord;
          resErr  <= nxtErr;
        end
      end
      if (ctl.divStep) begin
        rReg <= trialFits ? N_W'(trial - {1'b0, nVal}) : trial[N_W-1:0];
        qReg <= {qReg[LOG_W-2:0], trialFits};
      end
      if (ctl.finish) begin
        resWord <= rootWord;
        resErr  <= rootErr;
      end
    end
  end

  assign outData = ctl.sendHi ? resWord[63:32] : resWord[31:0];
  assign outErr  = resErr;

  AST_MUL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.start && opCode == OP_MUL && (aZ || bZ)) |=> (resWord[62] && !resErr)); // R3

  AST_DIV_BY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.start && opCode == OP_DIV && bZ) |=> (resErr && resWord[62])); // R4

  AST_SUB_CANCEL: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.start && opCode == OP_SUB && !aZ && !bZ && aS == bS && aL == bL) |=> resWord[62]); // R8

  AST_FAR_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.start && (opCode == OP_ADD || opCode == OP_SUB) && !aZ && !bZ && far)
      |=> (resWord[LOG_W-1:0] == $past(aL) || resWord[LOG_W-1:0] == $past(bL))); // R9

endmodule

// File: rtl/lns_unit.sv
module lns_unit
  import lns_pkg::*;
#(
  parameter int LOG_W  = 32,
  parameter int FRAC_W = 16,
  parameter int TAB_N  = 64,
  parameter int N_W    = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic [31:0] inData,
  input  logic [2:0]  inOp,
  output logic        outValid,
  input  logic        outReady,
  output logic [31:0] outData,
  output logic        outErr
);

  lnsStrobe_t ctl;
  logic       opIsRoot;

  lns_ctrl #(.LOG_W(LOG_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .opIsRoot (opIsRoot),
    .inReady  (inReady),
    .outValid (outValid),
    .ctl      (ctl)
  );

  lns_datapath #(.LOG_W(LOG_W), .FRAC_W(FRAC_W), .TAB_N(TAB_N), .N_W(N_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .inData   (inData),
    .inOp     (inOp),
    .opIsRoot (opIsRoot),
    .outData  (outData),
    .outErr   (outErr)
  );

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outErr))); // R2

endmodule

// File: tb/test_lns_unit.sv
`timescale 1ns/1ps
module test_lns_unit;

  localparam int          LW   = 32;
  localparam real         SC   = 65536.0;
  localparam logic [63:0] ZW   = 64'h4000_0000_0000_0000;
  localparam int          TOL  = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inData = '0;
  logic [2:0]  inOp = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] outData;
  logic        outErr;

  always #10 clk = ~clk;

  lns_unit i_lns_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inOp(inOp), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outErr(outErr)
  );

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;
  int acceptCyc = 0;
  bit busy = 0;
  bit finished = 0;

  logic [63:0] expW[$];
  bit          expE[$];
  int          expLat[$];
  bit          expTol[$];
  string       expTag[$];

  initial forever begin
    @(negedge clk);
    cyc++;
  end

  function automatic int lg(input real x);
    return int'(x * SC);
  endfunction

  function automatic logic [63:0] mk(input bit s, input int l);
    return {s, 1'b0, 30'd0, l[31:0]};
  endfunction

  // expected table sum, from the quantization rule of R7/R8
  function automatic int approx(input int big, input int k, input bit isSub);
    real c;
    if (isSub) c = $ln(1.0 - 2.0 ** (-(real'(k + 1)) / 4.0)) / $ln(2.0);
    else       c = $ln(1.0 + 2.0 ** (-(real'(k)) / 4.0)) / $ln(2.0);
    return big + int'(c * SC);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] w, input bit err, input bit tol, input string tag);
    logic [31:0] beats[4];
    int i;
    beats[0] = a[31:0]; beats[1] = a[63:32]; beats[2] = b[31:0]; beats[3] = b[63:32];
    expW.push_back(w); expE.push_back(err); expTol.push_back(tol); expTag.push_back(tag);
    expLat.push_back(op == 3'd3 ? LW + 3 : 2);  // R11, in half-cycle-shifted sample counts
    i = 0;
    while (i < 4) begin
      inValid = 1'b1; inData = beats[i]; inOp = (i == 0) ? op : 3'd7;
      if (inReady) begin
        if (i == 3) acceptCyc = cyc;
        i++;
      end
      @(negedge clk); #1;
    end
    inValid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    int beat = 0; int stallLeft = 0; int resN = 0; bit stalledLast = 0;
    logic [31:0] loWord = '0; logic [31:0] held = '0;
    logic [63:0] cw = '0; bit ce = 0; int cl = 0; bit ct = 0; string tg = "";
    @(posedge rstN);
    forever begin
      @(negedge clk); #1;
      if (outValid) begin
        if (stalledLast) check(outData == held, "R2 stalled beat hold", {32'd0, outData}, {32'd0, held});
        held = outData;
        if (!busy) begin
          busy = 1;
          if (expW.size() == 0) begin
            check(1'b0, "R11 unexpected result", {32'd0, outData}, 64'd0);
            cw = '0; ce = 0; cl = 0; ct = 0; tg = "none";
          end else begin
            cw = expW.pop_front(); ce = expE.pop_front(); cl = expLat.pop_front();
            ct = expTol.pop_front(); tg = expTag.pop_front();
            check(cyc - acceptCyc == cl, {"R11 latency ", tg}, 64'(cyc - acceptCyc), 64'(cl));
          end
          stallLeft = (resN % 3 == 1) ? 2 : 0;
        end
        if (stallLeft > 0) begin
          stallLeft--; outReady = 1'b0; stalledLast = 1;
        end else begin
          outReady = 1'b1; stalledLast = 0;
          if (beat == 0) begin
            loWord = outData; beat = 1;
          end else begin
            if (ct) begin
              int dlt;
              dlt = int'(loWord) - int'(cw[31:0]);
              check(outData == cw[63:32] && dlt <= TOL && dlt >= -TOL && outErr == ce,
                    tg, {outData, loWord}, cw);
            end else begin
              check({outData, loWord} == cw && outErr == ce, tg, {outData, loWord}, cw);
            end
            beat = 0; busy = 0; resN++;
          end
        end
      end else begin
        outReady = 1'b1; stalledLast = 0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  // stimulus
  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(inReady == 1'b1 && outValid == 1'b0, "R1 reset state", {62'd0, inReady, outValid}, 64'd2);

    // R1/R3 multiply
    runOp(3'd0, mk(0, lg(2.5)), mk(1, lg(-1.25)), mk(1, lg(1.25)), 0, 0, "R3 mul");
    runOp(3'd0, mk(1, lg(3.0)) | 64'h0000_0000_0000_0000, ZW, ZW, 0, 0, "R3 mul zero");
    runOp(3'd0, {1'b0, 1'b0, 30'h3fff_ffff, 32'(lg(1.0))}, mk(0, lg(2.0)), mk(0, lg(3.0)), 0, 0, "R1 pad bits ignored");
    // R4 divide
    runOp(3'd1, mk(1, lg(3.0)), mk(1, lg(5.5)), mk(0, lg(-2.5)), 0, 0, "R4 div");
    runOp(3'd1, mk(0, lg(1.0)), ZW, ZW, 1, 0, "R4 div by zero");
    runOp(3'd1, ZW, mk(0, lg(2.0)), ZW, 0, 0, "R4 zero dividend");
    // R5 power
    runOp(3'd2, mk(1, lg(1.5)), 64'd3, mk(1, lg(4.5)), 0, 0, "R5 pow odd");
    runOp(3'd2, mk(1, lg(1.5)), 64'd2, mk(0, lg(3.0)), 0, 0, "R5 pow even");
    runOp(3'd2, mk(1, lg(1.5)), 64'd0, mk(0, 0), 0, 0, "R5 pow zero exponent");
    runOp(3'd2, mk(1, lg(-0.75)), 64'd5, mk(1, lg(-3.75)), 0, 0, "R5 pow negative log");
    runOp(3'd2, ZW, 64'd4, ZW, 0, 0, "R5 pow zero base");
    // R6 root
    runOp(3'd3, mk(0, lg(7.0)), 64'd2, mk(0, lg(3.5)), 0, 0, "R6 root");
    runOp(3'd3, mk(1, lg(-7.0)), 64'd3, mk(1, -152917), 0, 0, "R6 root truncation");
    runOp(3'd3, mk(1, lg(2.0)), 64'd2, ZW, 1, 0, "R6 even root of negative");
    runOp(3'd3, mk(0, lg(2.0)), 64'd0, ZW, 1, 0, "R6 root n zero");
    runOp(3'd3, ZW, 64'd3, ZW, 0, 0, "R6 root of zero");
    // R7 same-sign sums
    runOp(3'd4, mk(0, lg(2.0)), mk(0, lg(2.0)), mk(0, lg(3.0)), 0, 0, "R7 add equal");
    runOp(3'd4, mk(0, lg(4.0)), mk(0, lg(3.0)), mk(0, approx(lg(4.0), 4, 0)), 0, 1, "R7 add d=1");
    runOp(3'd4, mk(0, lg(1.0)), mk(0, lg(1.6)), mk(0, approx(lg(1.6), 2, 0)), 0, 1, "R7 add B larger");
    runOp(3'd4, mk(0, lg(15.9)), mk(0, 0), mk(0, approx(lg(15.9), 63, 0)), 0, 1, "R7 add last entry");
    // R8 opposite-sign sums
    runOp(3'd5, mk(0, lg(5.0)), mk(0, lg(4.0)), mk(0, approx(lg(5.0), 4, 1)), 0, 1, "R8 sub");
    runOp(3'd4, mk(1, lg(2.0)), mk(0, lg(3.5)), mk(0, approx(lg(3.5), 6, 1)), 0, 1, "R8 add opposite");
    runOp(3'd5, mk(0, lg(1.0)), mk(0, lg(3.0)), mk(1, approx(lg(3.0), 8, 1)), 0, 1, "R8 sub B larger");
    runOp(3'd5, mk(1, lg(1.25)), mk(1, lg(1.25)), ZW, 0, 0, "R8 sub cancel");
    // R9 out of table range
    runOp(3'd4, mk(0, lg(-3.0)), mk(1, lg(17.0)), mk(1, lg(17.0)), 0, 0, "R9 far");
    runOp(3'd4, mk(0, lg(16.0)), mk(0, 0), mk(0, lg(16.0)), 0, 0, "R9 edge");
    // R10 zero operands
    runOp(3'd4, ZW, mk(1, lg(2.0)), mk(1, lg(2.0)), 0, 0, "R10 add zero A");
    runOp(3'd5, ZW, mk(0, lg(2.0)), mk(1, lg(2.0)), 0, 0, "R10 sub zero A");
    runOp(3'd5, mk(0, lg(2.0)), ZW, mk(0, lg(2.0)), 0, 0, "R10 sub zero B");
    runOp(3'd4, ZW, ZW, ZW, 0, 0, "R10 both zero");
    // R12 unused codes
    runOp(3'd6, mk(0, lg(1.0)), mk(0, lg(1.0)), ZW, 1, 0, "R12 code 6");
    runOp(3'd7, mk(0, lg(1.0)), mk(0, lg(1.0)), ZW, 1, 0, "R12 code 7");

    while (expW.size() != 0 || busy) @(negedge clk);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule